// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR flash. Every clock cycle it samples a write strobe together with an 18-bit word address and a 16-bit data word. It follows the multi-write unlock-and-command sequences that the flash accepts. When a sequence completes, it raises a request for one cycle with an operation code and that operation's arguments. The operations are word program, chip erase, sector erase, boot-block lockout, product-ID entry and product-ID exit. The cell array and its timing lie outside the block; the array reports back only through a `busy` input.

The decoder also keeps two flags. The first shows whether the device is in product-ID mode. The second shows whether the boot block is locked. The lock flag decides whether a sector erase aimed at the main array also takes the boot block with it.

The sequencer has these states:
- `S_IDLE`: waits for the first unlock write.
- `S_U1`: the first unlock write was seen.
- `S_U2`: both unlock writes were seen, and the command byte is next.
- `S_PROG`: waits for the program target write.
- `S_E0`: the erase/lock prefix was seen.
- `S_E1` and `S_E2`: the second unlock pair.
- `S_HOLD`: the array is busy.

Its transitions are:
- unlock advance: `S_IDLE`→`S_U1`→`S_U2`.
- program arm: `S_U2`→`S_PROG`.
- program issue: `S_PROG`→`S_IDLE`.
- erase prefix: `S_U2`→`S_E0`→`S_E1`→`S_E2`.
- erase/lock issue: `S_E2`→`S_IDLE`.
- ID entry/exit issue: `S_U2`→`S_IDLE`.
- single-write exit: `S_IDLE`→`S_IDLE`.
- mismatch abort: any step back to `S_IDLE`.
- busy hold: any state→`S_HOLD`.
- release: `S_HOLD`→`S_IDLE`, or `S_HOLD`→`S_U1`, where the hold state acts like idle once busy is low.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `req_valid`, `id_mode` and `boot_locked` are all 0.
- R2: Every multi-write command begins with low byte 0xAA at address 0x05555 and then low byte 0x55 at address 0x02AAA. Data bits 15..8 never affect decoding.
- R3: A third write of 0xA0 at 0x05555 arms program. The next write then produces a request with `req_op`=1 (program), `req_addr` equal to that write's address, and `req_data` equal to its full 16-bit data.
- R4: A third write of 0x80 at 0x05555, then 0xAA at 0x05555, then 0x55 at 0x02AAA, then 0x10 at 0x05555 gives `req_op`=2 (chip erase).
- R5: The same five-write prefix followed by 0x30 at a sector address gives `req_op`=3 (sector erase). `req_sector` is derived from address bits 17..12: 0x03 gives 1 (parameter block 1), 0x05 gives 2 (parameter block 2), and 0x3F gives 3 (main array). Any other value gives no request.
- R6: For a sector erase, `req_erase_boot` is 1 only when `req_sector` is 3 and the boot block is unlocked. It is 0 for parameter blocks and whenever the lock is set.
- R7: The prefix followed by 0x40 at 0x05555 gives `req_op`=4 (boot lockout). In the same cycle it sets `boot_locked`, which only reset clears.
- R8: A third write of 0x90 at 0x05555 gives `req_op`=5 and sets `id_mode`. A third write of 0xF0 at 0x05555 gives `req_op`=6 and clears `id_mode`. So does a single 0xF0 write to any address while idle.
- R9: A write whose address or low byte does not match the current step returns the decoder to idle and issues nothing.
- R10: While `busy` is 1, writes are ignored and any partial sequence is dropped. Once `busy` is 0 the decoder starts from idle.
- R11: Each request is valid for exactly one cycle, one cycle after the write that completes it. A cycle without a write produces no request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 18 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| busy | input | 1 | Array is executing an operation |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 3 | Operation code (1 program, 2 chip erase, 3 sector erase, 4 lockout, 5 ID entry, 6 ID exit) |
| req_addr | output | 18 | Address of the completing write |
| req_data | output | 16 | Data of the completing write |
| req_sector | output | 2 | Sector code for sector erase |
| req_erase_boot | output | 1 | Sector erase also covers the boot block |
| id_mode | output | 1 | Product-ID mode active |
| boot_locked | output | 1 | Boot block lockout set |

## Verification
The bench uses upper data bytes that are nonzero in unlock writes. A decoder that compared all 16 bits would then miss every command. It sends a broken third write and follows it with a lone 0xA0 and a data word. A decoder that stayed inside the sequence after a mismatch would issue a stray program. It runs main-array sector erases on both sides of the lockout, erases at an address outside the sector map, and starts a sequence before `busy` rises and finishes it after `busy` falls. A wrong coupling flag, a missing sector check, or a partial sequence that survives a busy period would each show up as an unexpected or mismatched request.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_CHIP   = 3'd2,
        OP_SECT   = 3'd3,
        OP_LOCK   = 3'd4,
        OP_ID_IN  = 3'd5,
        OP_ID_OUT = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        RG_NONE   = 2'd0,
        RG_PARAM1 = 2'd1,
        RG_PARAM2 = 2'd2,
        RG_MAIN   = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_U1,
        S_U2,
        S_PROG,
        S_E0,
        S_E1,
        S_E2,
        S_HOLD
    } state_e;

    localparam logic [7:0] K_UNLOCK_A = 8'hAA;
    localparam logic [7:0] K_UNLOCK_B = 8'h55;
    localparam logic [7:0] K_PROG     = 8'hA0;
    localparam logic [7:0] K_ERASE    = 8'h80;
    localparam logic [7:0] K_ID_IN    = 8'h90;
    localparam logic [7:0] K_ID_OUT   = 8'hF0;
    localparam logic [7:0] K_CHIP     = 8'h10;
    localparam logic [7:0] K_SECT     = 8'h30;
    localparam logic [7:0] K_LOCK     = 8'h40;

endpackage

// File: rtl/fcd_region_decode.sv
module fcd_region_decode #(
    parameter int TAG_W = 6,
    parameter logic [TAG_W-1:0] TAG_P1   = 6'h03,
    parameter logic [TAG_W-1:0] TAG_P2   = 6'h05,
    parameter logic [TAG_W-1:0] TAG_MAIN = 6'h3F
) (
    input  logic [TAG_W-1:0]       tag,
    output flash_cmd_pkg::region_e region
);
    import flash_cmd_pkg::*;

    localparam int N_RG = 3;
    localparam logic [TAG_W-1:0] TAGS [N_RG] = '{TAG_P1, TAG_P2, TAG_MAIN};

    logic [N_RG-1:0] hit;

    for (genvar gi = 0; gi < N_RG; gi++) begin : g_hit
        assign hit[gi] = (tag == TAGS[gi]);
    end

    always_comb begin
        if (hit[2])      region = RG_MAIN;
        else if (hit[1]) region = RG_PARAM2;
        else if (hit[0]) region = RG_PARAM1;
        else             region = RG_NONE;
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm #(
    parameter int ADDR_W = 18,
    parameter logic [ADDR_W-1:0] ADDR_A = 18'h05555,
    parameter logic [ADDR_W-1:0] ADDR_B = 18'h02AAA
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              cmd,
    input  logic                    busy,
    input  flash_cmd_pkg::region_e  region,
    output flash_cmd_pkg::op_e      issue_op
);
    import flash_cmd_pkg::*;

    state_e st, nxt;
    logic   at_a, at_b;

    assign at_a = (wr_addr == ADDR_A);
    assign at_b = (wr_addr == ADDR_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt      = st;
        issue_op = OP_NONE;
        if (busy) begin
            nxt = S_HOLD;
        end else begin
            unique case (st)
                S_IDLE, S_HOLD: begin
                    nxt = S_IDLE;
                    if (wr_en) begin
                        if (at_a && cmd == K_UNLOCK_A) nxt = S_U1;
                        else if (cmd == K_ID_OUT)      issue_op = OP_ID_OUT;
                    end
                end
                S_U1: if (wr_en) nxt = (at_b && cmd == K_UNLOCK_B) ? S_U2 : S_IDLE;
                S_U2: if (wr_en) begin
                    nxt = S_IDLE;
                    if (at_a) begin
                        case (cmd)
                            K_PROG:   nxt = S_PROG;
                            K_ERASE:  nxt = S_E0;
                            K_ID_IN:  issue_op = OP_ID_IN;
                            K_ID_OUT: issue_op = OP_ID_OUT;
                            default:  nxt = S_IDLE;
                        endcase
                    end
                end
                S_PROG: if (wr_en) begin
                    nxt      = S_IDLE;
                    issue_op = OP_PROG;
                end
                S_E0: if (wr_en) nxt = (at_a && cmd == K_UNLOCK_A) ? S_E1 : S_IDLE;
                S_E1: if (wr_en) nxt = (at_b && cmd == K_UNLOCK_B) ? S_E2 : S_IDLE;
                S_E2: if (wr_en) begin
                    nxt = S_IDLE;
                    if (at_a && cmd == K_CHIP)                   issue_op = OP_CHIP;
                    else if (at_a && cmd == K_LOCK)              issue_op = OP_LOCK;
                    else if (cmd == K_SECT && region != RG_NONE) issue_op = OP_SECT;
                end
            endcase
        end
    end
endmodule

// File: rtl/fcd_mode_flags.sv
module fcd_mode_flags (
    input  logic               clk,
    input  logic               rst_n,
    input  flash_cmd_pkg::op_e issue_op,
    output logic               id_mode,
    output logic               boot_locked
);
    import flash_cmd_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_mode     <= 1'b0;
            boot_locked <= 1'b0;
        end else begin
            if (issue_op == OP_ID_IN)       id_mode <= 1'b1;
            else if (issue_op == OP_ID_OUT) id_mode <= 1'b0;
            if (issue_op == OP_LOCK)        boot_locked <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int BLK_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [1:0]        req_sector,
    output logic              req_erase_boot,
    output logic              id_mode,
    output logic              boot_locked
);
    import flash_cmd_pkg::*;

    localparam int TAG_W = ADDR_W - BLK_SHIFT;

    region_e region;
    op_e     issue_op;

    fcd_region_decode #(.TAG_W(TAG_W)) u_region (
        .tag    (wr_addr[ADDR_W-1:BLK_SHIFT]),
        .region (region)
    );

    fcd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .cmd      (wr_data[7:0]),
        .busy     (busy),
        .region   (region),
        .issue_op (issue_op)
    );

    fcd_mode_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_op    (issue_op),
        .id_mode     (id_mode),
        .boot_locked (boot_locked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_valid      <= 1'b0;
            req_op         <= OP_NONE;
            req_addr       <= '0;
            req_data       <= '0;
            req_sector     <= RG_NONE;
            req_erase_boot <= 1'b0;
        end else begin
            req_valid      <= (issue_op != OP_NONE);
            req_op         <= issue_op;
            req_addr       <= wr_addr;
            req_data       <= wr_data;
            req_sector     <= (issue_op == OP_SECT) ? region : RG_NONE;
            req_erase_boot <= (issue_op == OP_SECT) && (region == RG_MAIN) && !boot_locked;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       busy,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic [1:0] req_sector,
    input logic       req_erase_boot,
    input logic       id_mode,
    input logic       boot_locked
);
    a_r11_no_write_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !req_valid);

    a_r11_valid_has_op: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_op != 3'd0));

    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !req_valid);

    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked);

    a_r7_lock_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |-> boot_locked);

    a_r6_locked_no_boot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3 && boot_locked) |-> !req_erase_boot);

    a_r6_param_no_boot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3 && req_sector != 2'd3) |-> !req_erase_boot);

    a_r8_id_enter_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5) |-> id_mode);

    a_r8_id_exit_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd6) |-> !id_mode);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .busy           (busy),
    .req_valid      (req_valid),
    .req_op         (req_op),
    .req_sector     (req_sector),
    .req_erase_boot (req_erase_boot),
    .id_mode        (id_mode),
    .boot_locked    (boot_locked)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [17:0] req_addr;
    logic [15:0] req_data;
    logic [1:0]  req_sector;
    logic        req_erase_boot;
    logic        id_mode;
    logic        boot_locked;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [39:0] v;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_sector(req_sector), .req_erase_boot(req_erase_boot),
        .id_mode(id_mode), .boot_locked(boot_locked)
    );

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_req(logic [2:0] op, logic [17:0] a, logic [15:0] d,
                              logic [1:0] sec, logic eb, string tag);
        exp_t e;
        e.v   = {op, sec, eb, a, d};
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(logic [17:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(18'h05555, 16'h3CAA);
        wr(18'h02AAA, 16'hC355);
    endtask

    task automatic prefix5();
        unlock();
        wr(18'h05555, 16'h0080);
        wr(18'h05555, 16'h00AA);
        wr(18'h02AAA, 16'h0055);
    endtask

    task automatic drained(string req);
        @(negedge clk);
        @(negedge clk);
        chk(q.size() == 0, req, "expected requests outstanding", q.size(), 0);
    endtask

    // monitor: pops one expected item per observed request (R11 one-cycle pulse)
    always @(negedge clk) begin
        if (rst_n && req_valid && !finished) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9/R10/R11", "unexpected request",
                    {req_op, req_sector, req_erase_boot, req_addr, req_data}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({req_op, req_sector, req_erase_boot, req_addr, req_data} == e.v,
                    e.tag, "request fields",
                    {req_op, req_sector, req_erase_boot, req_addr, req_data}, e.v);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 0,   "R1", "req_valid after reset", req_valid, 0);
        chk(id_mode == 0,     "R1", "id_mode after reset", id_mode, 0);
        chk(boot_locked == 0, "R1", "boot_locked after reset", boot_locked, 0);

        // R2 R3: program, upper bytes of unlock data nonzero
        unlock();
        wr(18'h05555, 16'hFFA0);
        expect_req(3'd1, 18'h12345, 16'hBEEF, 2'd0, 1'b0, "R2 R3 program");
        wr(18'h12345, 16'hBEEF);
        drained("R3");

        // R4 chip erase
        prefix5();
        expect_req(3'd2, 18'h05555, 16'h0010, 2'd0, 1'b0, "R4 chip erase");
        wr(18'h05555, 16'h0010);
        drained("R4");

        // R5 R6 sector erase main, unlocked -> boot included
        prefix5();
        expect_req(3'd3, 18'h3F123, 16'h0030, 2'd3, 1'b1, "R5 R6 main unlocked");
        wr(18'h3F123, 16'h0030);
        // parameter block 1
        prefix5();
        expect_req(3'd3, 18'h03ABC, 16'h0030, 2'd1, 1'b0, "R5 R6 param1");
        wr(18'h03ABC, 16'h0030);
        // parameter block 2
        prefix5();
        expect_req(3'd3, 18'h05001, 16'h0030, 2'd2, 1'b0, "R5 param2");
        wr(18'h05001, 16'h0030);
        // address outside sector map -> nothing
        prefix5();
        wr(18'h10000, 16'h0030);
        drained("R5");

        // R7 lockout
        prefix5();
        expect_req(3'd4, 18'h05555, 16'h0040, 2'd0, 1'b0, "R7 lockout");
        wr(18'h05555, 16'h0040);
        chk(boot_locked == 1, "R7", "boot_locked after lockout", boot_locked, 1);
        prefix5();
        expect_req(3'd3, 18'h3F000, 16'h0030, 2'd3, 1'b0, "R6 main locked");
        wr(18'h3F000, 16'h0030);
        drained("R6");
        chk(boot_locked == 1, "R7", "boot_locked stays set", boot_locked, 1);

        // R8 product ID
        unlock();
        expect_req(3'd5, 18'h05555, 16'h0090, 2'd0, 1'b0, "R8 id entry");
        wr(18'h05555, 16'h0090);
        chk(id_mode == 1, "R8", "id_mode after entry", id_mode, 1);
        unlock();
        expect_req(3'd6, 18'h05555, 16'h00F0, 2'd0, 1'b0, "R8 id exit 3-write");
        wr(18'h05555, 16'h00F0);
        chk(id_mode == 0, "R8", "id_mode after exit", id_mode, 0);
        unlock();
        expect_req(3'd5, 18'h05555, 16'h0090, 2'd0, 1'b0, "R8 id entry again");
        wr(18'h05555, 16'h0090);
        expect_req(3'd6, 18'h2B0C1, 16'h77F0, 2'd0, 1'b0, "R8 single-write exit");
        wr(18'h2B0C1, 16'h77F0);
        chk(id_mode == 0, "R8", "id_mode after single exit", id_mode, 0);
        drained("R8");

        // R9 mismatches: bad command byte, then lone A0 + word must not program
        unlock();
        wr(18'h05555, 16'h0077);
        wr(18'h05555, 16'h00A0);
        wr(18'h01111, 16'h2222);
        // wrong second unlock address
        wr(18'h05555, 16'h00AA);
        wr(18'h05555, 16'h0055);
        wr(18'h05555, 16'h0090);
        chk(id_mode == 0, "R9", "id_mode after broken entry", id_mode, 0);
        drained("R9");

        // R10 busy: full program during busy is ignored
        @(negedge clk); busy = 1'b1;
        unlock();
        wr(18'h05555, 16'h00A0);
        wr(18'h00100, 16'h1111);
        @(negedge clk); busy = 1'b0;
        drained("R10");
        // partial sequence dropped across busy
        unlock();
        @(negedge clk); busy = 1'b1;
        @(negedge clk); busy = 1'b0;
        wr(18'h05555, 16'h00A0);
        wr(18'h00200, 16'h3333);
        drained("R10");
        // works after busy
        unlock();
        wr(18'h05555, 16'h00A0);
        expect_req(3'd1, 18'h00300, 16'h4444, 2'd0, 1'b0, "R10 program after busy");
        wr(18'h00300, 16'h4444);
        drained("R10");

        // R11 idle cycles, then reset clears lock (R1 R7)
        repeat (5) @(negedge clk);
        chk(req_valid == 0, "R11", "no request without writes", req_valid, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(boot_locked == 0, "R7", "reset clears lock", boot_locked, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule